// File: doc/BRIEF.md
# Hypercube Node Router with Relative Addressing

This block is one node of a binary hypercube network. It forwards messages between its dimension links and a cluster of local processing elements. Every message carries an address relative to the node that holds it, with one bit for each dimension of the cube. The router sends a message across a dimension only where that address bit is 1, and it clears the bit as the message leaves. When the address reaches zero, the message has arrived and is handed to the local element named in the message.

Messages come in from the dimension links or from a local injection port. They wait in a shared buffer that keeps them in arrival order, and one message leaves the buffer per cycle. If the buffer fills up, the router makes room on purpose. It takes the buffered message with the lowest priority and sends it out along a dimension whose address bit is 0, setting that bit. The message then travels one extra hop, but the node keeps moving. Every outgoing path has a registered valid/ready stage.

Top module: `hc_router`

## Requirements
- R1: After reset every dimension output and the delivery output are not valid, the buffer is empty and the injection port shows ready.
- R2: A message word is {address[DIMS], element index[log2 NPE], priority[PRIO_W], data[DATA_W]}, with the data in the least significant bits. A buffered message with an all-zero address leaves on the delivery output when that output is free. It raises the one select bit that matches its element index and carries its data.
- R3: A buffered message with a nonzero address leaves on the lowest-indexed dimension whose address bit is 1 and whose output is free. That bit is cleared in the outgoing address.
- R4: At most one incoming message is accepted per cycle. The dimension inputs take precedence in ascending index order and the injection port comes last. Ready is raised only toward the input that wins.
- R5: While the buffer holds DEPTH messages, no input shows ready.
- R6: While the buffer is full, one message is deflected. It is the entry with a nonzero address and the smallest priority value; on a tie, the oldest such entry is chosen. It leaves on the lowest-indexed dimension whose address bit is 0 and whose output is free, and that bit is set in the outgoing address. This happens only if such a free dimension exists.
- R7: An output that is valid and not accepted keeps its valid flag and its contents unchanged. An output is free when it is empty or is being accepted in the same cycle.
- R8: One message leaves the buffer per cycle. Outside deflection, the oldest message that can leave is the one chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_in_valid | input | DIMS | Incoming message valid, one bit per dimension |
| link_in_ready | output | DIMS | Incoming message accepted, one bit per dimension |
| link_in_msg | input | DIMS*MSG_W | Incoming messages, dimension d in slice d |
| link_out_valid | output | DIMS | Outgoing message valid per dimension |
| link_out_ready | input | DIMS | Neighbour accepts the outgoing message |
| link_out_msg | output | DIMS*MSG_W | Outgoing messages, dimension d in slice d |
| inj_valid | input | 1 | Local message offered for injection |
| inj_ready | output | 1 | Local message accepted |
| inj_msg | input | MSG_W | Local message word |
| dlv_valid | output | 1 | Arrived message available for delivery |
| dlv_ready | input | 1 | Delivery accepted by the element memories |
| dlv_pe_sel | output | NPE | One-hot write select of the addressed element |
| dlv_data | output | DATA_W | Data written to the addressed element |

## Verification
The bench builds the router with its default parameters: 12 dimensions, 16 local elements, an 8-entry buffer and a 2-bit priority. With only eight entries, a handful of injections against stalled outputs fills the buffer. That puts back-pressure and both deflection cases within reach: the lowest priority chosen, and a priority tie settled by age, with a busy link skipped. With all twelve dimensions present, the random phase uses the full relative-address space.

// File: rtl/hc_router_pkg.sv
package hc_router_pkg;

  // kind of departure chosen for the buffer this cycle
  typedef enum logic [1:0] {
    DK_NONE  = 2'd0,
    DK_LOCAL = 2'd1,
    DK_FWD   = 2'd2,
    DK_DEFL  = 2'd3
  } disp_kind_t;

endpackage

// File: rtl/hc_in_arb.sv
module hc_in_arb #(
  parameter int DIMS  = 12,
  parameter int MSG_W = 34
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  space,
  input  logic [DIMS-1:0]       link_valid,
  output logic [DIMS-1:0]       link_ready,
  input  logic [DIMS*MSG_W-1:0] link_msg,
  input  logic                  inj_valid,
  output logic                  inj_ready,
  input  logic [MSG_W-1:0]      inj_msg,
  output logic                  acc,
  output logic [MSG_W-1:0]      acc_msg
);

  always_comb begin
    logic taken;
    taken      = 1'b0;
    link_ready = '0;
    inj_ready  = 1'b0;
    acc        = 1'b0;
    acc_msg    = '0;
    if (space) begin
      for (int d = 0; d < DIMS; d++) begin
        if (!taken && link_valid[d]) begin
          taken         = 1'b1;
          link_ready[d] = 1'b1;
          acc_msg       = link_msg[d*MSG_W +: MSG_W];
        end
      end
      if (!taken) begin
        inj_ready = 1'b1;
        if (inj_valid) begin
          taken   = 1'b1;
          acc_msg = inj_msg;
        end
      end
      acc = taken;
    end
  end

  // R4: never more than one accepted transfer per cycle
  a_r4_single_accept: assert property (@(posedge clk) disable iff (rst)
    $onehot0({link_valid & link_ready, inj_valid & inj_ready}));

  // R5: nothing is accepted without buffer space
  a_r5_no_accept_full: assert property (@(posedge clk) disable iff (rst)
    !space |-> (link_ready == '0 && !inj_ready));

endmodule

// File: rtl/hc_msg_queue.sv
module hc_msg_queue #(
  parameter int DEPTH = 8,
  parameter int MSG_W = 34,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [MSG_W-1:0]       wr_msg,
  input  logic                   rd_en,
  input  logic [IW-1:0]          rd_idx,
  output logic [DEPTH-1:0]       ent_valid,
  output logic [DEPTH*MSG_W-1:0] ent_msg,
  output logic                   full
);

  logic [MSG_W-1:0] slot [DEPTH];
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    wpos;

  assign full = (cnt == CW'(DEPTH));
  assign wpos = rd_en ? cnt - CW'(1) : cnt;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign ent_valid[i]              = (CW'(i) < cnt);
      assign ent_msg[i*MSG_W +: MSG_W] = slot[i];
    end
  endgenerate

  // slot 0 is always the oldest entry; a removal closes the gap
  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IW'(i) >= rd_idx) slot[i] <= slot[i+1];
      end
    end
    if (wr_en) slot[IW'(wpos)] <= wr_msg;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(wr_en) - CW'(rd_en);
  end

  // R5: occupancy never exceeds the depth
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R5: a full buffer is never written
  a_r5_no_write_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_en);

  // R8: a removal always names a live entry
  a_r8_read_live: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (CW'(rd_idx) < cnt));

endmodule

// File: rtl/hc_dispatch_sel.sv
module hc_dispatch_sel
  import hc_router_pkg::*;
#(
  parameter int DIMS     = 12,
  parameter int DEPTH    = 8,
  parameter int MSG_W    = 34,
  parameter int ADDR_LSB = 22,
  parameter int PRIO_LSB = 16,
  parameter int PRIO_W   = 2,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW = (DIMS > 1) ? $clog2(DIMS) : 1
) (
  input  logic [DEPTH-1:0]       ent_valid,
  input  logic [DEPTH*MSG_W-1:0] ent_msg,
  input  logic [DIMS-1:0]        link_free,
  input  logic                   dlv_free,
  input  logic                   full,
  output logic                   go,
  output disp_kind_t             go_kind,
  output logic [IW-1:0]          go_idx,
  output logic [DW-1:0]          go_dim,
  output logic [MSG_W-1:0]       go_msg
);

  logic [MSG_W-1:0]  msg_a  [DEPTH];
  logic [DIMS-1:0]   addr_a [DEPTH];
  logic [PRIO_W-1:0] prio_a [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_split
      assign msg_a[i]  = ent_msg[i*MSG_W +: MSG_W];
      assign addr_a[i] = msg_a[i][ADDR_LSB +: DIMS];
      assign prio_a[i] = msg_a[i][PRIO_LSB +: PRIO_W];
    end
  endgenerate

  function automatic logic [DW-1:0] low_one(input logic [DIMS-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    for (int k = DIMS - 1; k >= 0; k--) begin
      if (v[k]) r = DW'(k);
    end
    return r;
  endfunction

  // deflection victim: smallest priority among unarrived entries, oldest first
  logic              vic_have;
  logic [IW-1:0]     vic_idx;
  logic [PRIO_W-1:0] vic_prio;
  logic [DIMS-1:0]   vic_addr;
  logic [DIMS-1:0]   vic_opts;

  always_comb begin
    vic_have = 1'b0;
    vic_idx  = '0;
    vic_prio = '0;
    vic_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_valid[i] && addr_a[i] != '0 && (!vic_have || prio_a[i] < vic_prio)) begin
        vic_have = 1'b1;
        vic_idx  = IW'(i);
        vic_prio = prio_a[i];
        vic_addr = addr_a[i];
      end
    end
  end

  assign vic_opts = ~vic_addr & link_free;

  always_comb begin
    go      = 1'b0;
    go_kind = DK_NONE;
    go_idx  = '0;
    go_dim  = '0;
    go_msg  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!go && ent_valid[i]) begin
        if (addr_a[i] == '0) begin
          if (dlv_free) begin
            go      = 1'b1;
            go_kind = DK_LOCAL;
            go_idx  = IW'(i);
          end
        end else if ((addr_a[i] & link_free) != '0) begin
          go      = 1'b1;
          go_kind = DK_FWD;
          go_idx  = IW'(i);
          go_dim  = low_one(addr_a[i] & link_free);
        end
      end
    end
    if (full && vic_have && vic_opts != '0) begin
      go      = 1'b1;
      go_kind = DK_DEFL;
      go_idx  = vic_idx;
      go_dim  = low_one(vic_opts);
    end
    if (go) begin
      go_msg = msg_a[go_idx];
      if (go_kind != DK_LOCAL) go_msg[ADDR_LSB + int'(go_dim)] = ~go_msg[ADDR_LSB + int'(go_dim)];
    end
  end

endmodule

// File: rtl/hc_out_reg.sv
module hc_out_reg #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         free,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout
);

  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end

  // R7: a stalled output holds its contents
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(dout)));

  // R7: a stalled output is never overwritten
  a_r7_no_clobber: assert property (@(posedge clk) disable iff (rst)
    load |-> (!valid || ready));

endmodule

// File: rtl/hc_router.sv
module hc_router
  import hc_router_pkg::*;
#(
  parameter int DIMS   = 12,
  parameter int NPE    = 16,
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 2,
  parameter int DATA_W = 16,
  localparam int PE_W  = (NPE > 1) ? $clog2(NPE) : 1,
  localparam int MSG_W = DIMS + PE_W + PRIO_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIMS-1:0]       link_in_valid,
  output logic [DIMS-1:0]       link_in_ready,
  input  logic [DIMS*MSG_W-1:0] link_in_msg,
  output logic [DIMS-1:0]       link_out_valid,
  input  logic [DIMS-1:0]       link_out_ready,
  output logic [DIMS*MSG_W-1:0] link_out_msg,
  input  logic                  inj_valid,
  output logic                  inj_ready,
  input  logic [MSG_W-1:0]      inj_msg,
  output logic                  dlv_valid,
  input  logic                  dlv_ready,
  output logic [NPE-1:0]        dlv_pe_sel,
  output logic [DATA_W-1:0]     dlv_data
);

  localparam int PRIO_LSB = DATA_W;
  localparam int PE_LSB   = DATA_W + PRIO_W;
  localparam int ADDR_LSB = PE_LSB + PE_W;
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DW       = (DIMS > 1) ? $clog2(DIMS) : 1;

  logic                   q_full;
  logic                   acc;
  logic [MSG_W-1:0]       acc_msg;
  logic [DEPTH-1:0]       ent_valid;
  logic [DEPTH*MSG_W-1:0] ent_msg;
  logic                   go;
  disp_kind_t             go_kind;
  logic [IW-1:0]          go_idx;
  logic [DW-1:0]          go_dim;
  logic [MSG_W-1:0]       go_msg;
  logic [DIMS-1:0]        link_free;
  logic                   dlv_free;
  logic [NPE-1:0]         sel_next;

  hc_in_arb #(.DIMS(DIMS), .MSG_W(MSG_W)) u_arb (
    .clk(clk), .rst(rst), .space(!q_full),
    .link_valid(link_in_valid), .link_ready(link_in_ready), .link_msg(link_in_msg),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_msg(inj_msg),
    .acc(acc), .acc_msg(acc_msg)
  );

  hc_msg_queue #(.DEPTH(DEPTH), .MSG_W(MSG_W)) u_queue (
    .clk(clk), .rst(rst), .wr_en(acc), .wr_msg(acc_msg),
    .rd_en(go), .rd_idx(go_idx),
    .ent_valid(ent_valid), .ent_msg(ent_msg), .full(q_full)
  );

  hc_dispatch_sel #(
    .DIMS(DIMS), .DEPTH(DEPTH), .MSG_W(MSG_W),
    .ADDR_LSB(ADDR_LSB), .PRIO_LSB(PRIO_LSB), .PRIO_W(PRIO_W)
  ) u_sel (
    .ent_valid(ent_valid), .ent_msg(ent_msg), .link_free(link_free),
    .dlv_free(dlv_free), .full(q_full),
    .go(go), .go_kind(go_kind), .go_idx(go_idx), .go_dim(go_dim), .go_msg(go_msg)
  );

  generate
    for (genvar d = 0; d < DIMS; d++) begin : g_link
      hc_out_reg #(.W(MSG_W)) u_oreg (
        .clk(clk), .rst(rst),
        .load(go && go_kind != DK_LOCAL && go_dim == DW'(d)),
        .din(go_msg), .free(link_free[d]),
        .valid(link_out_valid[d]), .ready(link_out_ready[d]),
        .dout(link_out_msg[d*MSG_W +: MSG_W])
      );
    end
    for (genvar p = 0; p < NPE; p++) begin : g_sel
      assign sel_next[p] = (go_msg[PE_LSB +: PE_W] == PE_W'(p));
    end
  endgenerate

  hc_out_reg #(.W(NPE + DATA_W)) u_dreg (
    .clk(clk), .rst(rst),
    .load(go && go_kind == DK_LOCAL),
    .din({sel_next, go_msg[DATA_W-1:0]}), .free(dlv_free),
    .valid(dlv_valid), .ready(dlv_ready),
    .dout({dlv_pe_sel, dlv_data})
  );

  // R2: a delivery strobes exactly one element
  a_r2_onehot_select: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> $onehot(dlv_pe_sel));

  // R6: deflection only happens with a full buffer
  a_r6_defl_when_full: assert property (@(posedge clk) disable iff (rst)
    (go && go_kind == DK_DEFL) |-> (q_full && link_in_ready == '0 && !inj_ready));

endmodule

// File: tb/hc_router_tb.sv
module hc_router_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIMS   = 12;
  localparam int NPE    = 16;
  localparam int DEPTH  = 8;
  localparam int PRIO_W = 2;
  localparam int DATA_W = 16;
  localparam int PE_W   = 4;
  localparam int MSG_W  = DIMS + PE_W + PRIO_W + DATA_W;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [DIMS-1:0]       link_in_valid = '0;
  logic [DIMS-1:0]       link_in_ready;
  logic [DIMS*MSG_W-1:0] link_in_msg = '0;
  logic [DIMS-1:0]       link_out_valid;
  logic [DIMS-1:0]       link_out_ready = '0;
  logic [DIMS*MSG_W-1:0] link_out_msg;
  logic                  inj_valid = 1'b0;
  logic                  inj_ready;
  logic [MSG_W-1:0]      inj_msg = '0;
  logic                  dlv_valid;
  logic                  dlv_ready = 1'b0;
  logic [NPE-1:0]        dlv_pe_sel;
  logic [DATA_W-1:0]     dlv_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_router #(.DIMS(DIMS), .NPE(NPE), .DEPTH(DEPTH), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst),
    .link_in_valid(link_in_valid), .link_in_ready(link_in_ready), .link_in_msg(link_in_msg),
    .link_out_valid(link_out_valid), .link_out_ready(link_out_ready), .link_out_msg(link_out_msg),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_msg(inj_msg),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pe_sel(dlv_pe_sel), .dlv_data(dlv_data)
  );

  function automatic logic [MSG_W-1:0] mk(input logic [DIMS-1:0] a, input logic [PE_W-1:0] pe,
                                          input logic [PRIO_W-1:0] pr, input logic [DATA_W-1:0] dt);
    return {a, pe, pr, dt};
  endfunction

  function automatic int low_bit(input logic [DIMS-1:0] v);
    for (int k = 0; k < DIMS; k++) if (v[k]) return k;
    return -1;
  endfunction

  function automatic logic [MSG_W-1:0] out_of(input int d);
    return link_out_msg[d*MSG_W +: MSG_W];
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_inj(input logic [MSG_W-1:0] m);
    @(negedge clk);
    inj_msg   = m;
    inj_valid = 1'b1;
    #1;
    while (!inj_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // random-phase bookkeeping
  logic [DIMS-1:0] orig_addr [0:1023];
  logic [PE_W-1:0] orig_pe   [0:1023];
  int acc_cnt;
  int emit_cnt;

  task automatic check_emission();
    for (int d = 0; d < DIMS; d++) begin
      if (link_out_valid[d]) begin
        logic [MSG_W-1:0] m;
        int t;
        m = out_of(d);
        t = int'(m[DATA_W-1:0]);
        chk(t == emit_cnt, "R8 order", 64'(t), 64'(emit_cnt));
        chk(low_bit(orig_addr[t]) == d, "R3 dim", 64'(d), 64'(low_bit(orig_addr[t])));
        chk(m[MSG_W-1 -: DIMS] == (orig_addr[t] & ~(DIMS'(1) << d)), "R3 addr",
            64'(m[MSG_W-1 -: DIMS]), 64'(orig_addr[t] & ~(DIMS'(1) << d)));
        emit_cnt++;
      end
    end
    if (dlv_valid) begin
      int t;
      t = int'(dlv_data);
      chk(t == emit_cnt, "R8 order", 64'(t), 64'(emit_cnt));
      chk(orig_addr[t] == '0, "R2 arrived", 64'(orig_addr[t]), 64'(0));
      chk(dlv_pe_sel == (NPE'(1) << orig_pe[t]), "R2 select", 64'(dlv_pe_sel), 64'(NPE'(1) << orig_pe[t]));
      emit_cnt++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));

    // R1: reset state
    do_reset();
    #1;
    chk(link_out_valid == '0, "R1 link out", 64'(link_out_valid), 64'(0));
    chk(dlv_valid == 1'b0, "R1 delivery", 64'(dlv_valid), 64'(0));
    chk(inj_ready == 1'b1, "R1 inj ready", 64'(inj_ready), 64'(1));

    // R4: arbitration among simultaneous offers (withdrawn before the edge)
    @(negedge clk);
    link_in_valid = 12'h088;
    inj_valid     = 1'b1;
    #1;
    chk(link_in_ready == 12'h008, "R4 link grant", 64'(link_in_ready), 64'h8);
    chk(inj_ready == 1'b0, "R4 inj blocked", 64'(inj_ready), 64'(0));
    link_in_valid = '0;
    inj_valid     = 1'b0;

    // R2: local delivery of an arrived message
    link_out_ready = '1;
    dlv_ready      = 1'b1;
    send_inj(mk(12'h000, 4'd5, 2'd1, 16'hABCD));
    step();
    chk(dlv_valid && dlv_pe_sel == 16'h0020 && dlv_data == 16'hABCD, "R2 delivery",
        {31'd0, dlv_valid, dlv_pe_sel, dlv_data}, {31'd0, 1'b1, 16'h0020, 16'hABCD});
    step();
    chk(dlv_valid == 1'b0, "R2 delivery taken", 64'(dlv_valid), 64'(0));

    // R3 / R7: forwarding around a busy link, stalled output holds
    link_out_ready = '0;
    send_inj(mk(12'h004, 4'd1, 2'd1, 16'h0001));
    send_inj(mk(12'h00C, 4'd2, 2'd1, 16'h0002));
    step();
    chk(link_out_valid == 12'h00C, "R3 links used", 64'(link_out_valid), 64'h00C);
    chk(out_of(3) == mk(12'h004, 4'd2, 2'd1, 16'h0002), "R3 busy skipped", 64'(out_of(3)),
        64'(mk(12'h004, 4'd2, 2'd1, 16'h0002)));
    repeat (3) step();
    chk(link_out_valid[2] && out_of(2) == mk(12'h000, 4'd1, 2'd1, 16'h0001), "R7 hold",
        64'(out_of(2)), 64'(mk(12'h000, 4'd1, 2'd1, 16'h0001)));

    // R5 / R6: fill the buffer behind a stalled link, watch deflection
    do_reset();
    link_out_ready = '0;
    dlv_ready      = 1'b0;
    send_inj(mk(12'h001, 4'd0, 2'd3, 16'h0100));
    for (int i = 1; i <= 8; i++) begin
      send_inj(mk(12'h001, 4'd0, (i == 5) ? 2'd0 : 2'd3, 16'h0100 + 16'(i)));
    end
    #1;
    chk(inj_ready == 1'b0, "R5 full backpressure", 64'(inj_ready), 64'(0));
    step();
    chk(link_out_valid[1] && out_of(1) == mk(12'h003, 4'd0, 2'd0, 16'h0105), "R6 lowest prio",
        64'(out_of(1)), 64'(mk(12'h003, 4'd0, 2'd0, 16'h0105)));
    chk(inj_ready == 1'b1, "R5 space again", 64'(inj_ready), 64'(1));
    send_inj(mk(12'h001, 4'd0, 2'd3, 16'h0109));
    step();
    chk(link_out_valid[2] && out_of(2) == mk(12'h005, 4'd0, 2'd3, 16'h0101), "R6 tie oldest",
        64'(out_of(2)), 64'(mk(12'h005, 4'd0, 2'd3, 16'h0101)));
    chk(out_of(0) == mk(12'h000, 4'd0, 2'd3, 16'h0100), "R7 hold full",
        64'(out_of(0)), 64'(mk(12'h000, 4'd0, 2'd3, 16'h0100)));

    // random phase: all outputs ready, one offer per cycle
    do_reset();
    link_out_ready = '1;
    dlv_ready      = 1'b1;
    acc_cnt  = 0;
    emit_cnt = 0;
    for (int c = 0; c < 400; c++) begin
      check_emission();
      link_in_valid = '0;
      inj_valid     = 1'b0;
      if ($urandom_range(1, 0) == 1 && acc_cnt < 1000) begin
        logic [DIMS-1:0] a;
        logic [PE_W-1:0] pe;
        logic [MSG_W-1:0] m;
        a  = ($urandom_range(3, 0) == 0) ? '0 : DIMS'($urandom);
        pe = PE_W'($urandom);
        m  = mk(a, pe, PRIO_W'($urandom), DATA_W'(acc_cnt));
        orig_addr[acc_cnt] = a;
        orig_pe[acc_cnt]   = pe;
        if ($urandom_range(1, 0) == 1) begin
          int d;
          d = $urandom_range(DIMS - 1, 0);
          link_in_msg[d*MSG_W +: MSG_W] = m;
          link_in_valid[d] = 1'b1;
        end else begin
          inj_msg   = m;
          inj_valid = 1'b1;
        end
        #1;
        chk((link_in_ready | {11'd0, inj_ready}) != '0, "R4 accept", 64'(link_in_ready), 64'(1));
        acc_cnt++;
      end
      @(posedge clk);
      @(negedge clk);
    end
    link_in_valid = '0;
    inj_valid     = 1'b0;
    repeat (4) begin
      check_emission();
      step();
    end
    chk(emit_cnt == acc_cnt, "R8 all left", 64'(emit_cnt), 64'(acc_cnt));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule